// File: doc/BRIEF.md
# Audio Playback Fetch Engine

This block feeds a downstream audio serializer from memory. Software programs a base address and a length counted in 32-bit words through a small register port. With the engine enabled, writing the length starts a transfer. The engine reads memory one word per request at consecutive word addresses and pushes each returned word into an internal FIFO. The serializer drains the FIFO through a ready/valid port.

The FIFO fills until it is full and then waits. Fetching resumes only once the fill level has fallen to the depth minus a threshold, so refills come in bursts rather than one word at a time. When the last word of a transfer has entered the FIFO, a completion flag is latched. That flag drives a level interrupt unless it is masked. Reading the interrupt status register reports the flag and clears it.

A sticky underrun flag records that the serializer asked for data while the FIFO was empty. Writing zero to the control register aborts a transfer and empties the FIFO.

Top module: `audio_pb_engine`

## Requirements
- R1: After reset, `irq` and `outValid` are low, the interrupt mask register (0x14) reads 0xFFFFFFFF, and the FIFO status register (0x10) reads 0.
- R2: The read-only version register at 0x00 holds the patch level in bits 4:0, the minor revision in bits 10:5, the major revision in bits 16:11 and the licence type in bits 18:17. Each field is set by a top-level parameter.
- R3: Registers are control at 0x04 (bit 0 enables the engine), base address at 0x08 and length at 0x0C (bits 15:0, in words). A non-zero length write while the engine is enabled and idle starts fetching at the base address, and the address increases by 4 for each word.
- R4: The completion flag (interrupt status 0x18, bit 31) is set in the cycle the final word of a transfer is written into the FIFO. `irq` is high exactly when that flag is set and mask bit 31 is 0; a 1 in mask bit 31 masks it.
- R5: A read of the interrupt status register returns the pending flag, then clears it, so `irq` is low in the next cycle.
- R6: The FIFO holds DEPTH words. Once it is full, no new request is issued until the fill level is at or below DEPTH−THRESH.
- R7: FIFO status bits 31:20 give the current word count modulo 4096, and bit 1 is set while the FIFO is full.
- R8: A length write made while a transfer is still running has no effect: exactly the first programmed number of words is delivered.
- R9: Writing control with bit 0 clear stops fetching and empties the FIFO. Length writes made while the engine is disabled start nothing. The base address is kept.
- R10: When the engine is enabled and `outReady` is high while the FIFO is empty, FIFO status bit 0 becomes 1 and stays 1 until the FIFO status register is read.
- R11: Words leave the FIFO in fetch order, one per cycle with `outValid` and `outReady` both high. `outData` stays stable while it is presented and not accepted.
- R12: At most one memory read is outstanding. `memReq` lasts one cycle and the next request waits for `memRspValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears read-sensitive bits at the clock edge) |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr`, combinational |
| memReq | output | 1 | One-cycle memory read request |
| memAddr | output | 32 | Byte address of the requested word |
| memRspValid | input | 1 | Memory response strobe |
| memRspData | input | 32 | Memory response word |
| outValid | output | 1 | FIFO head word is available |
| outData | output | 32 | FIFO head word |
| outReady | input | 1 | Serializer accepts the head word |
| irq | output | 1 | Completion interrupt, level |

## Verification
The bench runs a small FIFO configuration, so every fill and refill boundary is reached in a few dozen cycles. Transfers are run in several forms:
- A short transfer that fits in the FIFO exercises completion, masking and clear-on-read without back-pressure.
- A transfer longer than the FIFO, drained one word at a time, shows that no refill starts above the threshold and that one starts exactly at it.
- A length write in the middle of the long transfer and a disable in the middle of another tell an ignored command apart from one that takes effect; the word count and the address sequence differ between the two.
- Requests against an empty FIFO, with and without a following status read, separate the sticky underrun bit from a live empty indication.

// File: rtl/audio_pb_pkg.sv
package audio_pb_pkg;
  localparam logic [7:0] OFS_VERSION = 8'h00;
  localparam logic [7:0] OFS_CTRL    = 8'h04;
  localparam logic [7:0] OFS_BASE    = 8'h08;
  localparam logic [7:0] OFS_LEN     = 8'h0C;
  localparam logic [7:0] OFS_FSTAT   = 8'h10;
  localparam logic [7:0] OFS_IMASK   = 8'h14;
  localparam logic [7:0] OFS_ISTAT   = 8'h18;

  localparam int DONE_BIT = 31;
  localparam int CNT_LSB  = 20;

  // strobes from control to the FIFO datapath
  typedef struct packed {
    logic        push;
    logic        flush;
    logic [31:0] pushData;
  } fifoCmd_t;
endpackage

// File: rtl/pb_fifo.sv
module pb_fifo
  import audio_pb_pkg::*;
#(
  parameter int DEPTH = 4096
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fifoCmd_t                     cmd,
  input  logic                         outReady,
  output logic                         outValid,
  output logic [31:0]                  outData,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [31:0]      store [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             pop;

  assign outValid = (count != '0);
  assign outData  = store[rdPtr];
  assign pop      = outValid && outReady;

  always_ff @(posedge clk) begin
    if (cmd.push) store[wrPtr] <= cmd.pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtr + 1'b1;
      if (pop)      rdPtr <= rdPtr + 1'b1;
      case ({cmd.push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |-> (count < CNT_W'(DEPTH)));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R11
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !cmd.flush) |=> (outValid && $stable(outData)));
endmodule

// File: rtl/pb_ctrl.sv
module pb_ctrl
  import audio_pb_pkg::*;
#(
  parameter int DEPTH     = 4096,
  parameter int THRESH    = 100,
  parameter int LEN_W     = 16,
  parameter int VER_PATCH = 0,
  parameter int VER_MINOR = 1,
  parameter int VER_MAJOR = 2,
  parameter int VER_LIC   = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic                        regRdEn,
  input  logic [7:0]                  regAddr,
  input  logic [31:0]                 regWrData,
  output logic [31:0]                 regRdData,
  output logic                        memReq,
  output logic [31:0]                 memAddr,
  input  logic                        memRspValid,
  input  logic [31:0]                 memRspData,
  input  logic [$clog2(DEPTH+1)-1:0]  fifoCount,
  input  logic                        outReady,
  output fifoCmd_t                    cmd,
  output logic                        irq
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LVL_W  = CNT_W + 1;
  localparam int RESUME = DEPTH - THRESH;
  localparam logic [31:0] VER_WORD = (32'(VER_LIC) << 17) | (32'(VER_MAJOR) << 11)
                                   | (32'(VER_MINOR) << 5) | 32'(VER_PATCH);

  logic             engEn, active, waiting, refillOk, donePend, underrun;
  logic [31:0]      baseAddr, curAddr, maskReg;
  logic [LEN_W-1:0] remain;
  logic [LVL_W-1:0] level;
  logic             ctrlWr, lenWr, launch, doneEvt, rdIstat, rdFstat, accept;
  logic [31:0]      cnt32;

  assign ctrlWr  = regWrEn && (regAddr == OFS_CTRL);
  assign lenWr   = regWrEn && (regAddr == OFS_LEN);
  assign launch  = lenWr && engEn && !active && (regWrData[LEN_W-1:0] != '0);
  assign rdIstat = regRdEn && (regAddr == OFS_ISTAT);
  assign rdFstat = regRdEn && (regAddr == OFS_FSTAT);
  assign accept  = memRspValid && waiting;
  assign doneEvt = accept && (remain == LEN_W'(1));
  assign level   = LVL_W'(fifoCount) + LVL_W'(waiting);

  assign memReq  = engEn && active && !waiting && refillOk && (level < LVL_W'(DEPTH));
  assign memAddr = curAddr;

  assign cmd.push     = accept;
  assign cmd.pushData = memRspData;
  assign cmd.flush    = ctrlWr && !regWrData[0];

  assign irq = donePend && !maskReg[DONE_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engEn    <= 1'b0;
      active   <= 1'b0;
      waiting  <= 1'b0;
      refillOk <= 1'b1;
      baseAddr <= '0;
      curAddr  <= '0;
      remain   <= '0;
      maskReg  <= '1;
    end else begin
      if (regWrEn && regAddr == OFS_BASE)  baseAddr <= regWrData;
      if (regWrEn && regAddr == OFS_IMASK) maskReg  <= regWrData;

      if (fifoCount <= CNT_W'(RESUME))      refillOk <= 1'b1;
      else if (level >= LVL_W'(DEPTH))      refillOk <= 1'b0;

      if (memReq) waiting <= 1'b1;
      if (accept) begin
        waiting <= 1'b0;
        curAddr <= curAddr + 32'd4;
        remain  <= remain - 1'b1;
        if (remain == LEN_W'(1)) active <= 1'b0;
      end

      if (launch) begin
        active  <= 1'b1;
        curAddr <= baseAddr;
        remain  <= regWrData[LEN_W-1:0];
      end

      if (ctrlWr) begin
        engEn <= regWrData[0];
        if (!regWrData[0]) begin
          active   <= 1'b0;
          waiting  <= 1'b0;
          refillOk <= 1'b1;
        end
      end
    end
  end

  // flags: a new event wins over a clearing read in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      donePend <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (doneEvt)      donePend <= 1'b1;
      else if (rdIstat) donePend <= 1'b0;
      if (engEn && outReady && fifoCount == '0) underrun <= 1'b1;
      else if (rdFstat)                         underrun <= 1'b0;
    end
  end

  always_comb begin
    cnt32     = 32'(fifoCount);
    regRdData = '0;
    case (regAddr)
      OFS_VERSION: regRdData = VER_WORD;
      OFS_CTRL:    regRdData = {31'b0, engEn};
      OFS_BASE:    regRdData = baseAddr;
      OFS_LEN:     regRdData = 32'(remain);
      OFS_FSTAT: begin
        regRdData[31:CNT_LSB] = cnt32[31-CNT_LSB:0];
        regRdData[1]          = (fifoCount == CNT_W'(DEPTH));
        regRdData[0]          = underrun;
      end
      OFS_IMASK:   regRdData = maskReg;
      OFS_ISTAT:   regRdData[DONE_BIT] = donePend;
      default:     regRdData = '0;
    endcase
  end

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIstat && !doneEvt) |=> !irq);

  // R12
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R9
  stop_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !regWrData[0]) |=> !memReq);

  // R4
  done_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |=> donePend);
endmodule

// File: rtl/audio_pb_engine.sv
module audio_pb_engine
  import audio_pb_pkg::*;
#(
  parameter int DEPTH     = 4096,
  parameter int THRESH    = 100,
  parameter int LEN_W     = 16,
  parameter int VER_PATCH = 0,
  parameter int VER_MINOR = 1,
  parameter int VER_MAJOR = 2,
  parameter int VER_LIC   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        outValid,
  output logic [31:0] outData,
  input  logic        outReady,
  output logic        irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoCmd_t          fifoCmd;
  logic [CNT_W-1:0]  fifoCount;

  pb_ctrl #(
    .DEPTH(DEPTH), .THRESH(THRESH), .LEN_W(LEN_W),
    .VER_PATCH(VER_PATCH), .VER_MINOR(VER_MINOR),
    .VER_MAJOR(VER_MAJOR), .VER_LIC(VER_LIC)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .memReq(memReq), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .fifoCount(fifoCount), .outReady(outReady),
    .cmd(fifoCmd), .irq(irq)
  );

  pb_fifo #(.DEPTH(DEPTH)) uFifo (
    .clk(clk), .rstN(rstN), .cmd(fifoCmd), .outReady(outReady),
    .outValid(outValid), .outData(outData), .count(fifoCount)
  );
endmodule

// File: tb/sim_audio_pb_engine.sv
module sim_audio_pb_engine;
  localparam int DEPTH  = 16;
  localparam int THRESH = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        outValid;
  logic [31:0] outData;
  logic        outReady = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  int reqSeen = 0;

  always #10 clk = ~clk;

  audio_pb_engine #(.DEPTH(DEPTH), .THRESH(THRESH)) u0 (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .memReq(memReq), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .irq(irq)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  // memory model: response two cycles after a request
  initial begin
    logic [31:0] a;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (memReq) begin
        a = memAddr;
        reqSeen++;
        @(negedge clk);
        @(negedge clk);
        memRspValid = 1'b1;
        memRspData  = memWord(a);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // take one word at a negedge where it is presented
  task automatic popWord(input string tag, input logic [31:0] exp);
    int w = 0;
    @(negedge clk);
    while (!outValid && w < 200) begin @(negedge clk); w++; end
    check(tag, outData, exp);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int reqBefore;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 outValid", {31'b0, outValid}, 32'd0);
    regRead(8'h14, d); check("R1 mask", d, 32'hFFFF_FFFF);
    regRead(8'h10, d); check("R1 fifo status", d, 32'd0);

    // R2 version fields
    regRead(8'h00, d);
    check("R2 version", d, (32'd2 << 17) | (32'd2 << 11) | (32'd1 << 5) | 32'd0);

    // short transfer, unmasked
    regWrite(8'h04, 32'd1);
    regWrite(8'h08, 32'h0000_1000);
    regWrite(8'h14, 32'd0);
    regWrite(8'h0C, 32'd5);
    idle(30);
    regRead(8'h10, d); check("R7 count 5", d, 32'd5 << 20);
    check("R4 irq unmasked", {31'b0, irq}, 32'd1);
    regRead(8'h18, d); check("R5 status pending", d, 32'h8000_0000);
    check("R5 irq cleared", {31'b0, irq}, 32'd0);
    regRead(8'h18, d); check("R5 status cleared", d, 32'd0);
    for (int i = 0; i < 5; i++) popWord("R3 R11 short data", memWord(32'h1000 + 32'(4 * i)));

    // long transfer with hysteresis and ignored length write
    regWrite(8'h08, 32'h0000_2000);
    regWrite(8'h0C, 32'd40);
    idle(80);
    regRead(8'h10, d); check("R6 R7 full", d, (32'd16 << 20) | 32'd2);
    regWrite(8'h0C, 32'd3);   // R8 ignored while active
    popWord("R11 long data", memWord(32'h2000));
    idle(20);
    regRead(8'h10, d); check("R6 no refill above threshold", d, 32'd15 << 20);
    popWord("R11 long data", memWord(32'h2004));
    popWord("R11 long data", memWord(32'h2008));
    idle(40);
    regRead(8'h10, d); check("R6 refill at threshold", d, (32'd16 << 20) | 32'd2);
    for (int i = 3; i < 40; i++) popWord("R3 R8 long data", memWord(32'h2000 + 32'(4 * i)));
    idle(30);
    check("R8 no extra words", {31'b0, outValid}, 32'd0);
    regRead(8'h18, d); check("R4 done after long", d, 32'h8000_0000);

    // masked completion
    regWrite(8'h14, 32'hFFFF_FFFF);
    regWrite(8'h08, 32'h0000_3000);
    regWrite(8'h0C, 32'd2);
    idle(20);
    check("R4 irq masked", {31'b0, irq}, 32'd0);
    regRead(8'h18, d); check("R4 masked still latched", d, 32'h8000_0000);
    popWord("R11 masked data", memWord(32'h3000));
    popWord("R11 masked data", memWord(32'h3004));

    // R10 underrun
    regRead(8'h10, d); check("R10 no underrun", d, 32'd0);
    @(negedge clk); outReady = 1'b1;
    idle(3); outReady = 1'b0;
    regRead(8'h10, d); check("R10 underrun set", d, 32'd1);
    regRead(8'h10, d); check("R10 underrun cleared", d, 32'd0);

    // R9 abort and disabled length write
    regWrite(8'h08, 32'h0000_4000);
    regWrite(8'h0C, 32'd20);
    idle(60);
    regWrite(8'h04, 32'd0);
    check("R9 flushed valid", {31'b0, outValid}, 32'd0);
    regRead(8'h10, d); check("R9 flushed count", d, 32'd0);
    reqBefore = reqSeen;
    regWrite(8'h0C, 32'd4);
    idle(20);
    regRead(8'h10, d); check("R9 disabled length ignored", d, 32'd0);
    check("R9 no requests", 32'(reqSeen - reqBefore), 32'd0);
    regWrite(8'h04, 32'd1);
    regWrite(8'h0C, 32'd2);
    idle(20);
    regRead(8'h10, d); check("R9 restart count", d, 32'd2 << 20);
    popWord("R9 base kept", memWord(32'h4000));
    popWord("R9 base kept", memWord(32'h4004));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule